// File: doc/BRIEF.md
# Host command queue fetch engine

This block moves 64-byte command packets from a circular queue in host memory into a local circular packet buffer. A doorbell input updates the host write index. Whenever the engine is idle, the host queue holds unfetched packets and the local buffer has free slots, it starts a fetch series. It reserves as many local slots as it can (the smaller of the pending count and the free count) and advances its host read index by that amount. It then issues memory read requests for the reserved packets.

The reserved run is cut into bursts that stop at the host ring wrap or at the local ring wrap. Each burst is cut again into chunks that stay inside a 4 KiB page. Each chunk request carries its host byte address, its packet count, and the local slot it fills. Only the final chunk of a burst carries a non-zero completion tag, which equals the burst length. The memory returns one in-order response per chunk, echoing the tag. A countdown of outstanding packets falls by each returned tag; when it reaches zero, a one-cycle done strobe tells the packet processor to run.

Doorbells that arrive during a series are held until it ends. When the local buffer is short of space the engine raises a stall flag and fetches again as soon as the consumer releases slots.

Top module: `cmdq_fetch_engine`

## Requirements
- R1: After reset `hq_rd_idx` is 0, and `rd_req_valid`, `fetch_done` and `stalled` are low.
- R2: A series starts only when the pending count (write index minus `hq_rd_idx`, modulo 2^IDX_W) is non-zero and free local slots exist. The grant is min(pending, free slots), free slots being LQ_DEPTH minus slots reserved and not yet released through `lb_release`. `hq_rd_idx` advances by exactly the grant in the cycle the series starts.
- R3: No chunk crosses the host ring wrap. With host ring size S = 2^`hq_size_lg`, a chunk starting at host index h holds at most S - (h mod S) packets.
- R4: No chunk crosses the local ring wrap. `rd_req_lidx` + `rd_req_pkts` never exceeds LQ_DEPTH. Local slots are filled consecutively, starting at slot 0 after reset.
- R5: The chunk address is `hq_base` + (h mod S) * 64. A chunk never crosses a 4096-byte page boundary.
- R6: A burst is min(host-wrap room, local-wrap room, granted packets left). Chunks hold min(burst packets left, packets left in the page). `rd_req_tag` equals the burst length on the chunk that ends the burst and is 0 on every other chunk.
- R7: `fetch_done` is a one-cycle pulse in the cycle after the response whose tag brings the sum of returned tags up to the grant. Only one series runs at a time, and `hq_rd_idx` does not move while a series is in flight.
- R8: At series start `stalled` becomes 1 if the pending count exceeds the grant and 0 otherwise. It is also set while idle with pending packets and no free slot.
- R9: While `rd_req_valid` is high and `rd_req_ready` is low, the request and all its fields are held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| db_valid | input | 1 | Doorbell strobe |
| db_wr_idx | input | IDX_W | New host write index |
| hq_base | input | ADDR_W | Host ring byte base address (64-byte aligned) |
| hq_size_lg | input | $clog2(IDX_W) | log2 of host ring entries |
| lb_release | input | 1 | Consumer frees local slots |
| lb_release_cnt | input | $clog2(LQ_DEPTH)+1 | Number of slots freed |
| rd_req_valid | output | 1 | Chunk read request valid |
| rd_req_ready | input | 1 | Memory accepts request |
| rd_req_addr | output | ADDR_W | Chunk host byte address |
| rd_req_pkts | output | $clog2(LQ_DEPTH)+1 | Packets in chunk |
| rd_req_lidx | output | $clog2(LQ_DEPTH) | First local slot of chunk |
| rd_req_tag | output | $clog2(LQ_DEPTH)+1 | Burst length on final chunk, else 0 |
| rd_rsp_valid | input | 1 | Chunk read completed (in order) |
| rd_rsp_tag | input | $clog2(LQ_DEPTH)+1 | Echoed request tag |
| hq_rd_idx | output | IDX_W | Host read index |
| stalled | output | 1 | Fetch held back by local space |
| fetch_done | output | 1 | Series complete, start processing |

## Verification
The bench runs three host ring layouts. One base is page aligned. One base sits a few packets before a page end, so chunks split at the page boundary apart from the ring wraps. One ring spans several pages and receives large doorbells. Single doorbells larger than the local buffer force partial grants and the stall flag. A design that ignored the local wrap or the page boundary would issue a chunk of the wrong length or address. A design that tagged every chunk would finish the countdown early and pulse done too soon. A design that let doorbells restart a series in flight would move the read index while busy.

// File: rtl/cfe_pkg.sv
package cfe_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_DRAIN = 2'd2
   } cfe_state_e;

   function automatic logic [63:0] umin(input logic [63:0] a, input logic [63:0] b);
      return (a < b) ? a : b;
   endfunction
endpackage

// File: rtl/cfe_slot_alloc.sv
module cfe_slot_alloc #(
   parameter int LQ_DEPTH = 16,
   parameter int IDX_W    = 32,
   localparam int LEN_W   = $clog2(LQ_DEPTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] want,
   input  logic             take,
   input  logic             rel,
   input  logic [LEN_W-1:0] rel_cnt,
   output logic [LEN_W-1:0] free_cnt,
   output logic [LEN_W-1:0] grant
);
   logic [LEN_W-1:0] free_q;

   always_comb begin
      grant = (64'(want) > 64'(free_q)) ? free_q : want[LEN_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         free_q <= LEN_W'(LQ_DEPTH);
      end else begin
         free_q <= free_q - (take ? grant : '0) + (rel ? rel_cnt : '0);
      end
   end

   assign free_cnt = free_q;
endmodule

// File: rtl/cfe_span_calc.sv
module cfe_span_calc
   import cfe_pkg::*;
#(
   parameter int IDX_W       = 32,
   parameter int ADDR_W      = 48,
   parameter int LQ_DEPTH    = 16,
   parameter int PKT_LG      = 6,
   parameter int PAGE_LG     = 12,
   parameter bit SPLIT_PAGES = 1'b1,
   localparam int LQ_W       = $clog2(LQ_DEPTH),
   localparam int LEN_W      = LQ_W + 1,
   localparam int SZ_W       = $clog2(IDX_W)
) (
   input  logic [IDX_W-1:0]  fptr,
   input  logic [LQ_W-1:0]   lwr,
   input  logic [SZ_W-1:0]   size_lg,
   input  logic [ADDR_W-1:0] base,
   input  logic [LEN_W-1:0]  grant_left,
   input  logic [LEN_W-1:0]  burst_left,
   output logic [LEN_W-1:0]  burst_len,
   output logic [LEN_W-1:0]  chunk_len,
   output logic [ADDR_W-1:0] chunk_addr
);
   logic [IDX_W-1:0] hsize, hoff, hwrap;
   logic [LEN_W-1:0] lwrap;
   logic [63:0]      page_room;

   always_comb begin
      hsize      = IDX_W'(1) << size_lg;
      hoff       = fptr & (hsize - IDX_W'(1));
      hwrap      = hsize - hoff;
      lwrap      = LEN_W'(LQ_DEPTH) - {1'b0, lwr};
      burst_len  = LEN_W'(umin(umin(64'(hwrap), 64'(lwrap)), 64'(grant_left)));
      chunk_addr = base + (ADDR_W'(hoff) << PKT_LG);
   end

   generate
      if (SPLIT_PAGES) begin : g_page
         localparam int PR_W = PAGE_LG + 1;
         logic [PR_W-1:0] bytes_left;
         always_comb begin
            bytes_left = PR_W'(1 << PAGE_LG) - {1'b0, chunk_addr[PAGE_LG-1:0]};
            page_room  = 64'(bytes_left >> PKT_LG);
         end
      end else begin : g_nopage
         always_comb page_room = 64'(burst_left);
      end
   endgenerate

   always_comb chunk_len = LEN_W'(umin(64'(burst_left), page_room));
endmodule

// File: rtl/cmdq_fetch_engine.sv
module cmdq_fetch_engine
   import cfe_pkg::*;
#(
   parameter int IDX_W       = 32,
   parameter int ADDR_W      = 48,
   parameter int LQ_DEPTH    = 16,
   parameter int PKT_LG      = 6,
   parameter int PAGE_LG     = 12,
   parameter bit SPLIT_PAGES = 1'b1,
   localparam int LQ_W       = $clog2(LQ_DEPTH),
   localparam int LEN_W      = LQ_W + 1,
   localparam int SZ_W       = $clog2(IDX_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              db_valid,
   input  logic [IDX_W-1:0]  db_wr_idx,
   input  logic [ADDR_W-1:0] hq_base,
   input  logic [SZ_W-1:0]   hq_size_lg,
   input  logic              lb_release,
   input  logic [LEN_W-1:0]  lb_release_cnt,
   output logic              rd_req_valid,
   input  logic              rd_req_ready,
   output logic [ADDR_W-1:0] rd_req_addr,
   output logic [LEN_W-1:0]  rd_req_pkts,
   output logic [LQ_W-1:0]   rd_req_lidx,
   output logic [LEN_W-1:0]  rd_req_tag,
   input  logic              rd_rsp_valid,
   input  logic [LEN_W-1:0]  rd_rsp_tag,
   output logic [IDX_W-1:0]  hq_rd_idx,
   output logic              stalled,
   output logic              fetch_done
);
   generate
      if ((LQ_DEPTH < 2) || ((LQ_DEPTH & (LQ_DEPTH - 1)) != 0)) begin : g_bad_depth
         $error("LQ_DEPTH must be a power of two of at least 2");
      end
      if (PAGE_LG <= PKT_LG) begin : g_bad_page
         $error("page must be larger than a packet");
      end
      if (ADDR_W <= IDX_W) begin : g_bad_addr
         $error("ADDR_W must exceed IDX_W");
      end
   endgenerate

   cfe_state_e       state;
   logic [IDX_W-1:0] hq_wr, hq_rd, fptr, pending;
   logic [LQ_W-1:0]  lwr;
   logic [LEN_W-1:0] grant_left, burst_left, burst_q, outstanding, out_next;
   logic [LEN_W-1:0] free_cnt, grant, burst_len, chunk_len;
   logic [ADDR_W-1:0] chunk_addr;
   logic             start, accept;

   always_comb begin
      pending  = hq_wr - hq_rd;
      start    = (state == ST_IDLE) && (pending != '0) && (free_cnt != '0);
      accept   = rd_req_valid && rd_req_ready;
      out_next = outstanding - (rd_rsp_valid ? rd_rsp_tag : '0);
   end

   cfe_slot_alloc #(.LQ_DEPTH(LQ_DEPTH), .IDX_W(IDX_W)) u_alloc (
      .clk      (clk),
      .rst_n    (rst_n),
      .want     (pending),
      .take     (start),
      .rel      (lb_release),
      .rel_cnt  (lb_release_cnt),
      .free_cnt (free_cnt),
      .grant    (grant)
   );

   cfe_span_calc #(
      .IDX_W(IDX_W), .ADDR_W(ADDR_W), .LQ_DEPTH(LQ_DEPTH),
      .PKT_LG(PKT_LG), .PAGE_LG(PAGE_LG), .SPLIT_PAGES(SPLIT_PAGES)
   ) u_span (
      .fptr       (fptr),
      .lwr        (lwr),
      .size_lg    (hq_size_lg),
      .base       (hq_base),
      .grant_left (grant_left),
      .burst_left (burst_left),
      .burst_len  (burst_len),
      .chunk_len  (chunk_len),
      .chunk_addr (chunk_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         hq_wr       <= '0;
         hq_rd       <= '0;
         fptr        <= '0;
         lwr         <= '0;
         grant_left  <= '0;
         burst_left  <= '0;
         burst_q     <= '0;
         outstanding <= '0;
         stalled     <= 1'b0;
         fetch_done  <= 1'b0;
      end else begin
         fetch_done  <= 1'b0;
         outstanding <= out_next;
         if (db_valid) hq_wr <= db_wr_idx;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  hq_rd       <= hq_rd + IDX_W'(grant);
                  grant_left  <= grant;
                  burst_left  <= '0;
                  outstanding <= grant;
                  stalled     <= (pending > IDX_W'(grant));
                  state       <= ST_ISSUE;
               end else if ((pending != '0) && (free_cnt == '0)) begin
                  stalled <= 1'b1;
               end
            end
            ST_ISSUE: begin
               if (burst_left == '0) begin
                  burst_left <= burst_len;
                  burst_q    <= burst_len;
               end else if (accept) begin
                  fptr       <= fptr + IDX_W'(chunk_len);
                  lwr        <= lwr + LQ_W'(chunk_len);
                  burst_left <= burst_left - chunk_len;
                  grant_left <= grant_left - chunk_len;
                  if (grant_left == chunk_len) state <= ST_DRAIN;
               end
            end
            ST_DRAIN: begin
               if (out_next == '0) begin
                  fetch_done <= 1'b1;
                  state      <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      rd_req_valid = (state == ST_ISSUE) && (burst_left != '0);
      rd_req_addr  = chunk_addr;
      rd_req_pkts  = chunk_len;
      rd_req_lidx  = lwr;
      rd_req_tag   = (chunk_len == burst_left) ? burst_q : '0;
      hq_rd_idx    = hq_rd;
   end
endmodule

// File: rtl/cmdq_fetch_engine_chk.sv
module cmdq_fetch_engine_chk
   import cfe_pkg::*;
#(
   parameter int IDX_W    = 32,
   parameter int ADDR_W   = 48,
   parameter int LQ_DEPTH = 16,
   parameter int PKT_LG   = 6,
   parameter int PAGE_LG  = 12,
   localparam int LQ_W    = $clog2(LQ_DEPTH),
   localparam int LEN_W   = LQ_W + 1,
   localparam int SZ_W    = $clog2(IDX_W)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] hq_base,
   input logic [SZ_W-1:0]   hq_size_lg,
   input logic              rd_req_valid,
   input logic              rd_req_ready,
   input logic [ADDR_W-1:0] rd_req_addr,
   input logic [LEN_W-1:0]  rd_req_pkts,
   input logic [LQ_W-1:0]   rd_req_lidx,
   input logic [LEN_W-1:0]  rd_req_tag,
   input logic [IDX_W-1:0]  hq_rd_idx,
   input logic              fetch_done,
   input cfe_state_e        state
);
   logic [63:0] page_end, host_slot, host_size;

   always_comb begin
      page_end  = 64'(rd_req_addr[PAGE_LG-1:0]) + (64'(rd_req_pkts) << PKT_LG);
      host_slot = 64'(rd_req_addr - hq_base) >> PKT_LG;
      host_size = 64'd1 << hq_size_lg;
   end

   assert_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_valid |-> (page_end <= (64'd1 << PAGE_LG)));

   assert_local_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_valid |-> ((64'(rd_req_lidx) + 64'(rd_req_pkts)) <= 64'(LQ_DEPTH)));

   assert_host_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_valid |-> ((host_slot + 64'(rd_req_pkts)) <= host_size));

   assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)
         && $stable(rd_req_pkts) && $stable(rd_req_lidx) && $stable(rd_req_tag)));

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_done |=> !fetch_done);

   assert_rd_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE) |=> $stable(hq_rd_idx));
endmodule

bind cmdq_fetch_engine cmdq_fetch_engine_chk #(
   .IDX_W(IDX_W), .ADDR_W(ADDR_W), .LQ_DEPTH(LQ_DEPTH),
   .PKT_LG(PKT_LG), .PAGE_LG(PAGE_LG)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .hq_base      (hq_base),
   .hq_size_lg   (hq_size_lg),
   .rd_req_valid (rd_req_valid),
   .rd_req_ready (rd_req_ready),
   .rd_req_addr  (rd_req_addr),
   .rd_req_pkts  (rd_req_pkts),
   .rd_req_lidx  (rd_req_lidx),
   .rd_req_tag   (rd_req_tag),
   .hq_rd_idx    (hq_rd_idx),
   .fetch_done   (fetch_done),
   .state        (state)
);

// File: tb/tb_cmdq_fetch_engine.sv
module tb_cmdq_fetch_engine;
   localparam int IDX_W = 32, ADDR_W = 48, LQ_DEPTH = 16;
   localparam int LQ_W = 4, LEN_W = 5, SZ_W = 5;

   logic              clk = 1'b0, rst_n = 1'b0;
   logic              db_valid = 1'b0;
   logic [IDX_W-1:0]  db_wr_idx = '0;
   logic [ADDR_W-1:0] hq_base = '0;
   logic [SZ_W-1:0]   hq_size_lg = 5'd4;
   logic              lb_release = 1'b0;
   logic [LEN_W-1:0]  lb_release_cnt = '0;
   logic              rd_req_valid, rd_req_ready = 1'b0;
   logic [ADDR_W-1:0] rd_req_addr;
   logic [LEN_W-1:0]  rd_req_pkts, rd_req_tag;
   logic [LQ_W-1:0]   rd_req_lidx;
   logic              rd_rsp_valid = 1'b0;
   logic [LEN_W-1:0]  rd_rsp_tag = '0;
   logic [IDX_W-1:0]  hq_rd_idx;
   logic              stalled, fetch_done;

   cmdq_fetch_engine dut (.*);

   always #10 clk = ~clk;

   int  n_checks = 0, n_fail = 0, cyc = 0;
   bit  run = 1'b0, busy = 1'b0, exp_done = 1'b0, big_db = 1'b0, gen_db = 1'b0;
   longint unsigned wr_drv, wr_seen, wr_old, rd_prev, held, grant_cur, rsp_sum;
   longint unsigned e_fptr, e_lidx, g_left, b_left, b_len;
   int  rsp_tag_q[$], rsp_due_q[$];

   task automatic check(input string req, input bit ok, input longint unsigned act,
                        input longint unsigned exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic longint unsigned umin(input longint unsigned a, input longint unsigned b);
      return (a < b) ? a : b;
   endfunction

   always @(negedge clk) begin
      if (run) begin
         longint unsigned hsz, hoff, addr, pg, ch, tg, exp_g, d;
         cyc++;
         wr_old  = wr_seen;
         wr_seen = wr_drv;
         // R7: done pulse exactly one cycle after the completing response
         if (fetch_done || exp_done)
            check("R7 done timing", fetch_done == exp_done, fetch_done, exp_done);
         if (fetch_done) busy = 1'b0;
         exp_done = 1'b0;
         // R2 / R7 / R8 at series start
         if (hq_rd_idx != IDX_W'(rd_prev)) begin
            d     = longint'(IDX_W'(hq_rd_idx - IDX_W'(rd_prev)));
            exp_g = umin(wr_old - rd_prev, LQ_DEPTH - held);
            check("R7 no restart while busy", !busy, busy, 0);
            check("R2 grant", d == exp_g, d, exp_g);
            check("R8 stall flag", stalled == ((wr_old - rd_prev) > exp_g), stalled,
                  (wr_old - rd_prev) > exp_g);
            rd_prev  += d;
            held     += d;
            busy      = 1'b1;
            grant_cur = d;
            g_left    = d;
            b_left    = 0;
            rsp_sum   = 0;
         end
         // memory model: choose ready, then score the handshake at the coming edge
         rd_req_ready = ($urandom_range(0, 3) != 0);
         if (rd_req_valid && rd_req_ready) begin
            hsz  = 64'd1 << hq_size_lg;
            hoff = e_fptr % hsz;
            addr = hq_base + hoff * 64;
            if (b_left == 0) begin
               b_len  = umin(umin(hsz - hoff, LQ_DEPTH - e_lidx), g_left);
               b_left = b_len;
            end
            pg = (4096 - (addr % 4096)) / 64;
            ch = umin(b_left, pg);
            tg = (ch == b_left) ? b_len : 0;
            check("R5 chunk address", rd_req_addr == ADDR_W'(addr), rd_req_addr, addr);
            check("R4 local slot", rd_req_lidx == LQ_W'(e_lidx), rd_req_lidx, e_lidx);
            check("R3 chunk length", rd_req_pkts == LEN_W'(ch), rd_req_pkts, ch);
            check("R6 completion tag", rd_req_tag == LEN_W'(tg), rd_req_tag, tg);
            e_fptr += ch;
            e_lidx  = (e_lidx + ch) % LQ_DEPTH;
            b_left -= ch;
            g_left -= ch;
            rsp_tag_q.push_back(int'(rd_req_tag));
            rsp_due_q.push_back(cyc + 1 + $urandom_range(0, 4));
         end
         rd_rsp_valid = 1'b0;
         rd_rsp_tag   = '0;
         if (rsp_due_q.size() > 0 && rsp_due_q[0] <= cyc) begin
            void'(rsp_due_q.pop_front());
            rd_rsp_valid = 1'b1;
            rd_rsp_tag   = LEN_W'(rsp_tag_q.pop_front());
            rsp_sum     += rd_rsp_tag;
            if (rd_rsp_tag != 0 && rsp_sum == grant_cur) exp_done = 1'b1;
         end
         // host producer
         db_valid = 1'b0;
         if (big_db) begin
            big_db    = 1'b0;
            wr_drv   += 40;
            db_valid  = 1'b1;
            db_wr_idx = IDX_W'(wr_drv);
         end else if (gen_db && $urandom_range(0, 5) == 0) begin
            hsz = 64'd1 << hq_size_lg;
            d   = umin(20, hsz - (wr_drv - longint'(hq_rd_idx)));
            wr_drv   += $urandom_range(0, int'(d));
            db_valid  = 1'b1;
            db_wr_idx = IDX_W'(wr_drv);
         end
         // consumer frees slots while a series runs or when space is exhausted
         lb_release = 1'b0;
         if ((busy || held == LQ_DEPTH) && held > 0 && $urandom_range(0, 3) == 0) begin
            d = $urandom_range(1, int'(held));
            held          -= d;
            lb_release     = 1'b1;
            lb_release_cnt = LEN_W'(d);
         end
         if (cyc > 150000) begin
            check("watchdog", 1'b0, cyc, 0);
            run = 1'b0;
         end
      end
   end

   task automatic do_phase(input logic [ADDR_W-1:0] base, input int lg, input bit burst40);
      @(negedge clk);
      run = 1'b0; rst_n = 1'b0; db_valid = 1'b0; lb_release = 1'b0;
      rd_rsp_valid = 1'b0; rd_req_ready = 1'b0;
      hq_base = base; hq_size_lg = SZ_W'(lg);
      wr_drv = 0; wr_seen = 0; rd_prev = 0; held = 0; busy = 0; exp_done = 0;
      e_fptr = 0; e_lidx = 0; g_left = 0; b_left = 0;
      rsp_tag_q.delete(); rsp_due_q.delete();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset rd index", hq_rd_idx == 0, hq_rd_idx, 0);
      check("R1 reset outputs", {rd_req_valid, fetch_done, stalled} == 3'b000,
            {rd_req_valid, fetch_done, stalled}, 0);
      big_db = burst40;
      gen_db = 1'b1;
      run    = 1'b1;
      repeat (2500) @(negedge clk);
      gen_db = 1'b0;
      for (int i = 0; i < 20000 && run; i++) begin
         @(negedge clk);
         if (!busy && longint'(hq_rd_idx) == wr_drv && rsp_due_q.size() == 0) break;
      end
      @(negedge clk);
      check("R2 all fetched", longint'(hq_rd_idx) == wr_drv, hq_rd_idx, wr_drv);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      do_phase(48'h0000_1000_0000, 4, 1'b0);
      do_phase(48'h0000_2000_0F40, 6, 1'b1);
      do_phase(48'h0000_3000_0800, 8, 1'b1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule